// File: doc/BRIEF.md
# Per-Channel Bidirectional TDM Loopback Switch

This block sits between a system-side serial channel bus and a line-side framer on a 24-slot time-division multiplexed link. Each cycle that carries a timeslot gives the block one byte from the system side and one byte from the line side, both for the same channel index. The block returns one byte toward the system and one byte toward the line for that channel. When no loop is set, the system byte goes to the line and the line byte goes to the system.

Every channel has its own control register with two loop enables. The local loop returns the system-side transmit byte to the same channel on the system-side receive output. The remote loop returns the line-side receive byte to the same timeslot on the line-side transmit output. The two enables are independent, so one channel can be looped in one direction, in both directions or in neither. Any set of channels may be looped at the same time.

Register writes go to a pending copy. The setting each channel uses is copied from the pending copy only at a frame boundary, so a frame never mixes old and new settings and no channel byte is split. Framing, serial-to-parallel conversion and elastic buffering happen outside this block.

Top module: `tdm_loop_switch`

## Requirements
- R1: While reset is held and after it is released, `outValid`, `outChan`, `sysOutByte` and `lineOutByte` are zero, and every channel's loop enables are clear. The first frame after reset is therefore passed straight through.
- R2: A slot presented with `slotValid` high produces its output bytes one clock later, with `outValid` high and `outChan` equal to the slot's index. A cycle without `slotValid` gives `outValid` low one clock later and leaves both output bytes unchanged.
- R3: When bit 4 of a channel's register is set, that channel's `sysOutByte` equals its `sysInByte`.
- R4: When bit 5 of a channel's register is set, that channel's `lineOutByte` equals its `lineInByte`.
- R5: When a channel's loop bit is clear, the data in that direction passes through: `sysOutByte` equals `lineInByte` when bit 4 is clear, and `lineOutByte` equals `sysInByte` when bit 5 is clear.
- R6: With bits 4 and 5 both set, both loops are active at once: `sysOutByte` carries `sysInByte` and `lineOutByte` carries `lineInByte`.
- R7: Each channel's enables act only on that channel's slots. Any combination of looped channels may be active within one frame.
- R8: A register write takes effect at the next frame boundary, which is a slot with `frameStart` high. From that slot onward, the frame uses the pending settings as they stood before that cycle. A write in the same cycle as the boundary slot applies from the following frame.
- R9: Writes to addresses 24 to 31 change no channel. Write-data bits other than 4 and 5 have no effect.
- R10: A slot whose index is 24 or more is always passed straight through in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Register address; channel n's register is at address n |
| wrData | input | 8 | Write data; bit 4 is the local loop enable, bit 5 is the remote loop enable |
| slotValid | input | 1 | A timeslot is present this cycle |
| frameStart | input | 1 | This slot is the first of a frame |
| slotChan | input | 5 | Channel index of the slot |
| sysInByte | input | 8 | Byte from the system side (system transmit) |
| lineInByte | input | 8 | Byte from the line side (line receive) |
| outValid | output | 1 | Output bytes belong to a slot |
| outChan | output | 5 | Channel index of the output bytes |
| sysOutByte | output | 8 | Byte toward the system side (system receive) |
| lineOutByte | output | 8 | Byte toward the line side (line transmit) |

## Verification
The assertions check on every cycle that the output bytes follow the loop strobes chosen by the control side for the previous slot. They also check that idle cycles hold the outputs and that out-of-range slot indices always pass through. What the strobes should have been, however, depends on the history of register writes. The bench's scenarios show this: writes deferred to the frame boundary, a write landing exactly on the boundary slot, writes to unused addresses, and mixed per-channel settings within one frame.

// File: rtl/tdmlp_pkg.sv
`timescale 1ns/1ps
package tdmlp_pkg;

  // Strobes handed from the control side to the byte datapath each cycle.
  typedef struct packed {
    logic take;        // a slot is present and must be registered
    logic localLoop;   // system byte returns toward the system
    logic remoteLoop;  // line byte returns toward the line
  } ctrlStrobes_t;

endpackage

// File: rtl/tdmlp_ctrl.sv
`timescale 1ns/1ps
module tdmlp_ctrl
  import tdmlp_pkg::*;
#(
  parameter int NUM_CHAN   = 24,
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 8,
  parameter int LOCAL_BIT  = 4,
  parameter int REMOTE_BIT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              slotValid,
  input  logic              frameStart,
  input  logic [ADDR_W-1:0] slotChan,
  output ctrlStrobes_t      strobes
);

  localparam int SPAN = 1 << ADDR_W;

  // Address decode, one hit line per implemented channel; unused entries stay low.
  logic [SPAN-1:0] wrHit;
  genvar g;
  generate
    for (g = 0; g < SPAN; g++) begin : g_dec
      if (g < NUM_CHAN) begin : g_live
        assign wrHit[g] = wrEn && (wrAddr == ADDR_W'(g));
      end else begin : g_dead
        assign wrHit[g] = 1'b0;
      end
    end
  endgenerate

  logic [SPAN-1:0] pendLoc, pendRem;  // written by software
  logic [SPAN-1:0] actLoc, actRem;    // used by the current frame
  logic            frameEdge;

  assign frameEdge = slotValid && frameStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendLoc <= '0;
      pendRem <= '0;
    end else begin
      for (int i = 0; i < SPAN; i++) begin
        if (wrHit[i]) begin
          pendLoc[i] <= wrData[LOCAL_BIT];
          pendRem[i] <= wrData[REMOTE_BIT];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actLoc <= '0;
      actRem <= '0;
    end else if (frameEdge) begin
      actLoc <= pendLoc;
      actRem <= pendRem;
    end
  end

  // The boundary slot already uses the settings being copied in.
  logic curLoc, curRem;
  always_comb begin
    curLoc = frameEdge ? pendLoc[slotChan] : actLoc[slotChan];
    curRem = frameEdge ? pendRem[slotChan] : actRem[slotChan];
  end

  always_comb begin
    strobes.take       = slotValid;
    strobes.localLoop  = slotValid && curLoc;
    strobes.remoteLoop = slotValid && curRem;
  end

endmodule

// File: rtl/tdmlp_path.sv
`timescale 1ns/1ps
module tdmlp_path
  import tdmlp_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] slotChan,
  input  logic [DATA_W-1:0] sysInByte,
  input  logic [DATA_W-1:0] lineInByte,
  output logic              outValid,
  output logic [ADDR_W-1:0] outChan,
  output logic [DATA_W-1:0] sysOutByte,
  output logic [DATA_W-1:0] lineOutByte
);

  logic [DATA_W-1:0] sysNext, lineNext;

  always_comb begin
    sysNext  = strobes.localLoop  ? sysInByte  : lineInByte;
    lineNext = strobes.remoteLoop ? lineInByte : sysInByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      outChan     <= '0;
      sysOutByte  <= '0;
      lineOutByte <= '0;
    end else begin
      outValid <= strobes.take;
      if (strobes.take) begin
        outChan     <= slotChan;
        sysOutByte  <= sysNext;
        lineOutByte <= lineNext;
      end
    end
  end

endmodule

// File: rtl/tdm_loop_switch.sv
`timescale 1ns/1ps
module tdm_loop_switch
  import tdmlp_pkg::*;
#(
  parameter int NUM_CHAN   = 24,
  parameter int DATA_W     = 8,
  parameter int LOCAL_BIT  = 4,
  parameter int REMOTE_BIT = 5,
  localparam int ADDR_W    = $clog2(NUM_CHAN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              slotValid,
  input  logic              frameStart,
  input  logic [ADDR_W-1:0] slotChan,
  input  logic [DATA_W-1:0] sysInByte,
  input  logic [DATA_W-1:0] lineInByte,
  output logic              outValid,
  output logic [ADDR_W-1:0] outChan,
  output logic [DATA_W-1:0] sysOutByte,
  output logic [DATA_W-1:0] lineOutByte
);

  ctrlStrobes_t strobes;

  tdmlp_ctrl #(
    .NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LOCAL_BIT(LOCAL_BIT), .REMOTE_BIT(REMOTE_BIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .slotValid(slotValid), .frameStart(frameStart), .slotChan(slotChan),
    .strobes(strobes)
  );

  tdmlp_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
    .clk(clk), .rstN(rstN),
    .strobes(strobes), .slotChan(slotChan),
    .sysInByte(sysInByte), .lineInByte(lineInByte),
    .outValid(outValid), .outChan(outChan),
    .sysOutByte(sysOutByte), .lineOutByte(lineOutByte)
  );

endmodule

// File: rtl/tdmlp_checker.sv
`timescale 1ns/1ps
module tdmlp_checker
  import tdmlp_pkg::*;
#(
  parameter int NUM_CHAN = 24,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              slotValid,
  input logic [ADDR_W-1:0] slotChan,
  input logic [DATA_W-1:0] sysInByte,
  input logic [DATA_W-1:0] lineInByte,
  input ctrlStrobes_t      strobes,
  input logic              outValid,
  input logic [ADDR_W-1:0] outChan,
  input logic [DATA_W-1:0] sysOutByte,
  input logic [DATA_W-1:0] lineOutByte
);

  AST_LOCAL_LOOP: assert property (@(posedge clk) disable iff (!rstN)
    slotValid && strobes.localLoop |=> sysOutByte == $past(sysInByte)); // R3

  AST_REMOTE_LOOP: assert property (@(posedge clk) disable iff (!rstN)
    slotValid && strobes.remoteLoop |=> lineOutByte == $past(lineInByte)); // R4

  AST_SYS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    slotValid && !strobes.localLoop |=> sysOutByte == $past(lineInByte)); // R5

  AST_LINE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    slotValid && !strobes.remoteLoop |=> lineOutByte == $past(sysInByte)); // R5

  AST_SLOT_OUT: assert property (@(posedge clk) disable iff (!rstN)
    slotValid |=> outValid && outChan == $past(slotChan)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !slotValid |=> !outValid && $stable(sysOutByte) && $stable(lineOutByte)); // R2

  AST_RANGE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    slotValid && (int'(slotChan) >= NUM_CHAN) |=>
      sysOutByte == $past(lineInByte) && lineOutByte == $past(sysInByte)); // R10

endmodule

bind tdm_loop_switch tdmlp_checker #(
  .NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rstN(rstN),
  .slotValid(slotValid), .slotChan(slotChan),
  .sysInByte(sysInByte), .lineInByte(lineInByte),
  .strobes(strobes),
  .outValid(outValid), .outChan(outChan),
  .sysOutByte(sysOutByte), .lineOutByte(lineOutByte)
);

// File: tb/sim_tdm_loop_switch.sv
`timescale 1ns/1ps
module sim_tdm_loop_switch;

  localparam int NC = 24;
  localparam int AW = 5;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN;
  logic          wrEn, slotValid, frameStart;
  logic [AW-1:0] wrAddr, slotChan, outChan;
  logic [DW-1:0] wrData, sysInByte, lineInByte, sysOutByte, lineOutByte;
  logic          outValid;

  always #2 clk = ~clk;

  tdm_loop_switch u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .slotValid(slotValid), .frameStart(frameStart), .slotChan(slotChan),
    .sysInByte(sysInByte), .lineInByte(lineInByte),
    .outValid(outValid), .outChan(outChan),
    .sysOutByte(sysOutByte), .lineOutByte(lineOutByte)
  );

  int compared = 0;
  int mismatched = 0;

  // Requirement-level model of the register set.
  bit pendL[32], pendR[32], actL[32], actR[32];

  function automatic string modeTag(int ch, bit l, bit r);
    if (ch >= NC) return "R10";
    if (l && r) return "R6";
    if (l) return "R3";
    if (r) return "R4";
    return "R5";
  endfunction

  function automatic logic [DW-1:0] expSys(int ch, bit l, logic [DW-1:0] s, logic [DW-1:0] ln);
    return (ch < NC && l) ? s : ln;
  endfunction

  function automatic logic [DW-1:0] expLine(int ch, bit r, logic [DW-1:0] s, logic [DW-1:0] ln);
    return (ch < NC && r) ? ln : s;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doCycle(bit sv, int ch, bit fs, logic [DW-1:0] sb, logic [DW-1:0] lb,
                         bit we, int wa, logic [DW-1:0] wd, string tagOvr);
    bit effL, effR;
    logic [DW-1:0] holdS, holdL, eS, eL;
    string tg;
    @(negedge clk);
    holdS = sysOutByte;
    holdL = lineOutByte;
    slotValid  = sv;
    slotChan   = AW'(ch);
    frameStart = fs;
    sysInByte  = sb;
    lineInByte = lb;
    wrEn       = we;
    wrAddr     = AW'(wa);
    wrData     = wd;
    effL = (ch < NC) ? (fs ? pendL[ch] : actL[ch]) : 1'b0;
    effR = (ch < NC) ? (fs ? pendR[ch] : actR[ch]) : 1'b0;
    eS = expSys(ch, effL, sb, lb);
    eL = expLine(ch, effR, sb, lb);
    tg = (tagOvr != "") ? tagOvr : modeTag(ch, effL, effR);
    if (sv && fs) begin
      for (int i = 0; i < 32; i++) begin actL[i] = pendL[i]; actR[i] = pendR[i]; end
    end
    if (we && wa < NC) begin
      pendL[wa] = wd[4];
      pendR[wa] = wd[5];
    end
    @(posedge clk);
    #1;
    if (sv) begin
      chk(tg, "sysOutByte", int'(sysOutByte), int'(eS));
      chk(tg, "lineOutByte", int'(lineOutByte), int'(eL));
      chk("R2", "outValid", int'(outValid), 1);
      chk("R2", "outChan", int'(outChan), ch);
    end else begin
      chk("R2", "outValid idle", int'(outValid), 0);
      chk("R2", "sysOutByte idle hold", int'(sysOutByte), int'(holdS));
      chk("R2", "lineOutByte idle hold", int'(lineOutByte), int'(holdL));
    end
  endtask

  task automatic idleWrite(int wa, logic [DW-1:0] wd, string tg);
    doCycle(1'b0, 0, 1'b0, 8'h00, 8'h00, 1'b1, wa, wd, tg);
  endtask

  // One frame; an optional write rides along with slot wrSlot.
  task automatic runFrame(int wrSlot, int wa, logic [DW-1:0] wd, string tg);
    for (int s = 0; s < NC; s++)
      doCycle(1'b1, s, s == 0, DW'($urandom), DW'($urandom), s == wrSlot, wa, wd, tg);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rstN = 1'b0; wrEn = 0; wrAddr = 0; wrData = 0;
    slotValid = 0; frameStart = 0; slotChan = 0; sysInByte = 0; lineInByte = 0;
    repeat (4) @(posedge clk);
    #1;
    chk("R1", "outValid in reset", int'(outValid), 0);
    chk("R1", "sysOutByte in reset", int'(sysOutByte), 0);
    chk("R1", "lineOutByte in reset", int'(lineOutByte), 0);
    chk("R1", "outChan in reset", int'(outChan), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1", "sysOutByte after reset", int'(sysOutByte), 0);

    // R1: first frame after reset passes straight through.
    runFrame(-1, 0, 0, "R1");

    // R9: unused addresses and non-loop bits change nothing.
    for (int a = NC; a < 32; a++) idleWrite(a, 8'h30, "");
    idleWrite(3, 8'hCF, "");
    runFrame(-1, 0, 0, "R9");
    runFrame(-1, 0, 0, "R9");

    // R8: write mid-frame to channel 5; current frame unchanged, next frame looped.
    runFrame(2, 5, 8'h10, "R8");
    runFrame(-1, 0, 0, "");
    // R8: write on the boundary slot applies one frame later.
    runFrame(0, 5, 8'h20, "R8");
    runFrame(-1, 0, 0, "R8");
    runFrame(-1, 0, 0, "");

    // R7: mixed per-channel settings in one frame.
    for (int c = 0; c < NC; c++) idleWrite(c, DW'((c % 4) << 4), "");
    runFrame(-1, 0, 0, "R7");
    runFrame(-1, 0, 0, "");

    // R6: both loops on every channel.
    for (int c = 0; c < NC; c++) idleWrite(c, 8'h30, "");
    runFrame(-1, 0, 0, "R6");

    // Random frames with gaps, stray writes and out-of-range slots (R10).
    for (int f = 0; f < 60; f++) begin
      for (int s = 0; s < NC; s++) begin
        if ($urandom_range(5) == 0)
          doCycle(1'b0, 0, 1'b0, 8'h00, 8'h00, $urandom_range(1) == 1,
                  $urandom_range(31), DW'($urandom), "");
        doCycle(1'b1, s, s == 0, DW'($urandom), DW'($urandom),
                $urandom_range(4) == 0, $urandom_range(31), DW'($urandom), "");
      end
      if ($urandom_range(2) == 0)
        doCycle(1'b1, NC + $urandom_range(7), 1'b0, DW'($urandom), DW'($urandom),
                1'b0, 0, 8'h00, "R10");
    end

    doCycle(1'b0, 0, 1'b0, 8'h00, 8'h00, 1'b0, 0, 8'h00, "");
    summary();
    $finish;
  end

endmodule